// File: doc/BRIEF.md
# Buffered Pulse-Width Modulator with Selectable Polarity

This block produces one pulse-width modulated output from a 10-bit up-counter. The counter advances on a prescaled tick and runs from zero up to a programmed period value, so one output cycle lasts period+1 ticks. In each cycle the first `duty` ticks form the active portion of the waveform. A polarity bit decides whether that active portion is driven high or low.

Software programs the block through a byte-wide write port. There are four registers: control, period low byte, duty low byte, and a shared register that holds the upper bits of both values. A duty write lands in a holding copy first. The running comparator takes the new value only when the current cycle ends, so every cycle is whole. Because the period compare reads the period register directly, changing only the period alters the frequency but keeps the absolute active time. Two corner values give fixed levels: a duty of zero holds the output at the inactive level, and a duty equal to the period holds it at the active level.

Top module: `pwm_unit`

## Requirements
- R1: After reset all registers are zero, the counter does not advance, and `pwmOut` is 1 (the inactive level for polarity 0). It stays 1 until the block is started.
- R2: While running at divide-by-1 with duty D and period P, where 0 < D < P, each cycle spans P+1 clocks. Exactly D of those clocks are in the active portion.
- R3: Write addresses are: 0 = control (bit0 run, bit1 polarity, bits[3:2] clock select), 1 = period[7:0], 2 = duty[7:0], 3 = upper bits. In the upper-bits register, bits[3:2] hold period[9:8] and bits[1:0] hold duty[9:8].
- R4: Clock select 00 ticks the counter every clock, 01 every 2 clocks, and both 10 and 11 every 8 clocks.
- R5: A written duty value reaches the output only after the current cycle ends. The first cycle after starting from reset is therefore fully inactive, even if a duty value is already loaded.
- R6: Writing only a new period leaves the active time per cycle unchanged.
- R7: With polarity 1 the active portion is driven high. With polarity 0 it is driven low.
- R8: When the active duty equals or exceeds the period, the output holds the active level continuously.
- R9: When the active duty is zero, the output holds the inactive level continuously. This takes priority over R8.
- R10: With the run bit cleared, the counter and the output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | 8 | Register write data |
| pwmOut | output | 1 | Modulated output |

## Verification
The bench uses the default parameters: a 10-bit count with 8-bit low registers and prescaler divisors of 2 and 8. With these values a period of 300 is reachable, which exercises the upper-bits field. The small divisors keep the divide-by-8 windows short enough to run every select code. Duty time is measured by counting output samples over windows that span whole cycles, so the result does not depend on the counter's phase. The only phase-exact check is the first cycle after a start from reset, where the starting count is known to be zero.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef struct packed {
    logic tick;
    logic wrap;
  } pwmStrobe_t;

  typedef enum logic [1:0] {
    SEL_DIV1  = 2'b00,
    SEL_DIV2  = 2'b01,
    SEL_DIV8A = 2'b10,
    SEL_DIV8B = 2'b11
  } clkSel_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_DUTY   = 2'd2;
  localparam logic [1:0] ADDR_UPPER  = 2'd3;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [LOW_W-1:0] wrData,
  output logic             run,
  output logic             polarity,
  output clkSel_e          clkSel,
  output logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] dutyMaster
);

  localparam int HI_W = CNT_W - LOW_W;

  logic [LOW_W-1:0] periodLow, dutyLow;
  logic [HI_W-1:0]  periodHigh, dutyHigh;
  logic [3:0]       ctrlReg;
  logic             unusedCtrlBits;

  assign unusedCtrlBits = ^wrData[LOW_W-1:4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      periodLow  <= '0;
      dutyLow    <= '0;
      periodHigh <= '0;
      dutyHigh   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL:   ctrlReg   <= wrData[3:0];
        ADDR_PERIOD: periodLow <= wrData;
        ADDR_DUTY:   dutyLow   <= wrData;
        default: begin
          periodHigh <= wrData[2*HI_W-1:HI_W];
          dutyHigh   <= wrData[HI_W-1:0];
        end
      endcase
    end
  end

  assign run        = ctrlReg[0];
  assign polarity   = ctrlReg[1];
  assign clkSel     = clkSel_e'(ctrlReg[3:2]);
  assign periodVal  = {periodHigh, periodLow};
  assign dutyMaster = {dutyHigh, dutyLow};

  AST_UPPER_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_UPPER) |=> (periodVal[CNT_W-1:LOW_W] == $past(wrData[2*HI_W-1:HI_W]) &&
                                        dutyMaster[CNT_W-1:LOW_W] == $past(wrData[HI_W-1:0]))); // R3

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int DIV_MID  = 2,
  parameter int DIV_SLOW = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  clkSel_e    clkSel,
  input  logic       atEnd,
  output pwmStrobe_t strb
);

  localparam int PRE_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
  localparam logic [PRE_W-1:0] LIM_MID  = PRE_W'(DIV_MID - 1);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);

  logic [PRE_W-1:0] preCnt, divLimit;
  logic             preDone;

  always_comb begin
    case (clkSel)
      SEL_DIV1: divLimit = '0;
      SEL_DIV2: divLimit = LIM_MID;
      default:  divLimit = LIM_SLOW;
    endcase
  end

  assign preDone = (preCnt >= divLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (!run)    preCnt <= '0;
    else if (preDone) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  assign strb.tick = run && preDone;
  assign strb.wrap = strb.tick && atEnd;

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> !strb.tick); // R10

  AST_DIV2_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && clkSel == SEL_DIV2) |=> (!strb.tick || clkSel != SEL_DIV2 || !run)); // R4

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strb,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] dutyMaster,
  input  logic             polarity,
  output logic             atEnd,
  output logic             pwmOut
);

  logic [CNT_W-1:0] cnt, dutySlave;
  logic             active, dutyZero, dutyFull;

  assign atEnd = (cnt >= periodVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (strb.tick) cnt <= atEnd ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dutySlave <= '0;
    else if (strb.wrap) dutySlave <= dutyMaster;
  end

  assign dutyZero = (dutySlave == '0);
  assign dutyFull = (dutySlave >= periodVal);
  assign active   = !dutyZero && (dutyFull || cnt < dutySlave);
  assign pwmOut   = polarity ? active : !active;

  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && atEnd) |=> (cnt == '0)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !atEnd) |=> (cnt == $past(cnt) + 1'b1)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> $stable(cnt)); // R10

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrap |=> $stable(dutySlave)); // R5

  AST_DUTY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> (dutySlave == $past(dutyMaster))); // R5

  AST_ZERO_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (dutySlave == '0) |-> (pwmOut == !polarity)); // R9

  AST_FULL_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (dutySlave != '0 && dutySlave == periodVal) |-> (pwmOut == polarity)); // R8

endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
  import pwm_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int LOW_W    = 8,
  parameter int DIV_MID  = 2,
  parameter int DIV_SLOW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [LOW_W-1:0] wrData,
  output logic             pwmOut
);

  logic             run, polarity, atEnd;
  clkSel_e          clkSel;
  logic [CNT_W-1:0] periodVal, dutyMaster;
  pwmStrobe_t       strb;

  pwm_regs #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .run(run), .polarity(polarity), .clkSel(clkSel),
    .periodVal(periodVal), .dutyMaster(dutyMaster)
  );

  pwm_ctrl #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) i_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .clkSel(clkSel),
    .atEnd(atEnd), .strb(strb)
  );

  pwm_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .periodVal(periodVal),
    .dutyMaster(dutyMaster), .polarity(polarity),
    .atEnd(atEnd), .pwmOut(pwmOut)
  );

endmodule

// File: tb/test_pwm_unit.sv
`timescale 1ns/1ps
module test_pwm_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pwmOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwm_unit i_pwm_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut) highs++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int h;
    @(negedge clk);
    check("R1 output after reset", pwmOut, 1);
    measure(20, h);
    check("R1 idle before start", h, 20);
  endtask

  task automatic t_basic;
    int h;
    wr(2'd1, 8'd9); wr(2'd2, 8'd3); wr(2'd3, 8'h00);
    wr(2'd0, 8'h01);
    measure(10, h);
    check("R5 first cycle inactive", h, 10);
    measure(10, h);
    check("R2 one cycle P=9 D=3", h, 7);
    measure(20, h);
    check("R2 two cycles P=9 D=3", h, 14);
  endtask

  task automatic t_dutyChange;
    int h;
    wr(2'd2, 8'd6);
    skip(20);
    measure(20, h);
    check("R5 new duty after boundary", h, 8);
  endtask

  task automatic t_periodOnly;
    int h;
    wr(2'd1, 8'd19);
    skip(40);
    measure(40, h);
    check("R6 period change keeps duty", h, 28);
  endtask

  task automatic t_upperBits;
    int h;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd44); wr(2'd2, 8'd100); wr(2'd3, 8'h04);
    wr(2'd0, 8'h01);
    skip(602);
    measure(602, h);
    check("R3 period 300 duty 100", h, 402);
  endtask

  task automatic t_polarity;
    int h;
    wr(2'd0, 8'h03);
    measure(602, h);
    check("R7 polarity high active", h, 200);
  endtask

  task automatic t_full;
    int h;
    wr(2'd2, 8'd44); wr(2'd3, 8'h05);
    skip(700);
    measure(100, h);
    check("R8 duty equals period", h, 100);
  endtask

  task automatic t_zero;
    int h;
    wr(2'd2, 8'd0); wr(2'd3, 8'h04);
    skip(700);
    measure(100, h);
    check("R9 duty zero pol1", h, 0);
    wr(2'd0, 8'h01);
    measure(100, h);
    check("R9 duty zero pol0", h, 100);
  endtask

  task automatic t_prescale;
    int h;
    wr(2'd1, 8'd9); wr(2'd2, 8'd3); wr(2'd3, 8'h00);
    wr(2'd0, 8'h05);
    skip(200);
    measure(40, h);
    check("R4 divide by 2", h, 28);
    wr(2'd0, 8'h09);
    skip(200);
    measure(160, h);
    check("R4 divide by 8 sel 10", h, 112);
    wr(2'd0, 8'h0D);
    skip(200);
    measure(160, h);
    check("R4 divide by 8 sel 11", h, 112);
  endtask

  task automatic t_stop;
    int h;
    int lvl;
    wr(2'd0, 8'h01);
    skip(4);
    wr(2'd0, 8'h00);
    lvl = pwmOut;
    measure(50, h);
    check("R10 stopped output holds", h, 50 * lvl);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_dutyChange();
    t_periodOnly();
    t_upperBits();
    t_polarity();
    t_full();
    t_zero();
    t_prescale();
    t_stop();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule